// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block sits between a system I/O bus and the embedded microcontroller of a keyboard controller. The host sees two byte-wide I/O ports. One carries data and the other carries commands and status. A host write to either port lands in one shared input byte and raises the input-full flag. A status bit records which port the write used, so the firmware can tell a command from a data byte. The firmware loads the output byte. That raises the output-full flag and one of two interrupt lines toward the host: keyboard or mouse.

The firmware side can read the input byte, which drains the input-full flag. It can load the output byte, clear the output-full flag and the interrupts, and drive the free bits of the status byte. A control input decides how the output side is cleared. When it is set, a host read of the data port clears the output-full flag and the interrupts in hardware. When it is clear, only the firmware can clear them. All state changes on one clock. The host strobes last one cycle each.

Top module: `kbc_host_if`

## Requirements
- R1: A host write (`host_wr`) to the data port address (parameter `DATA_PORT`, default 0x60) stores `host_wdata` in the input byte, sets status bit 1 (input full) and clears status bit 3 (command flag) on the next clock.
- R2: A host write to the command port address (parameter `CMD_PORT`, default 0x64) stores the byte, sets status bit 1 and sets status bit 3 on the next clock.
- R3: `host_rdata` shows the output byte while `host_addr` equals the data port, the status byte while it equals the command port, and 0xFF at any other address. Host writes and reads at any other address change no state.
- R4: A firmware read strobe (`ec_in_rd`) clears status bit 1 on the next clock. If a valid host write arrives in the same cycle, the write wins and bit 1 stays set.
- R5: A firmware load (`ec_out_wr`) stores `ec_out_data`, sets status bit 0 (output full) and asserts `kirq` when `ec_out_aux` is 0 or `mirq` when it is 1, with the other line low. Neither interrupt is ever high while bit 0 is clear.
- R6: While `hw_clear_en` is 1, a host read of the data port clears status bit 0, `kirq` and `mirq` on the next clock. A firmware load in the same cycle takes precedence.
- R7: While `hw_clear_en` is 0, a host read of the data port leaves status bit 0, `kirq` and `mirq` unchanged. The firmware strobe `ec_obf_clr` clears all three.
- R8: A host write that arrives while status bit 1 is already set replaces the input byte and updates bit 3. Nothing else in the status byte changes.
- R9: A firmware status write (`ec_ctl_wr`) sets status bits 2 and 7..4 from `ec_ctl_data` and does not alter bits 0, 1 and 3. Those five bits hold their value otherwise.
- R10: While `rst_n` is low at a clock edge, the status byte, the input byte, the output byte, `kirq` and `mirq` all become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, selected by address |
| hw_clear_en | input | 1 | Lets host data reads clear output-full and interrupts |
| ec_in_rd | input | 1 | Firmware read of the input byte, clears input full |
| ec_in_data | output | 8 | Input byte last written by the host |
| ec_in_cmd | output | 1 | Last host write used the command port |
| ec_out_wr | input | 1 | Firmware load of the output byte |
| ec_out_data | input | 8 | Output byte to load |
| ec_out_aux | input | 1 | Load targets the mouse interrupt |
| ec_obf_clr | input | 1 | Firmware clear of output full and both interrupts |
| ec_ctl_wr | input | 1 | Firmware write of the free status bits |
| ec_ctl_data | input | 8 | Value for status bits 2 and 7..4 |
| ec_status | output | 8 | Full status byte as seen by the host |
| kirq | output | 1 | Keyboard interrupt to the host |
| mirq | output | 1 | Mouse interrupt to the host |

## Verification
Directed sequences place a data write after a command write, and a second write on top of an unread one, so a stuck or swapped command flag shows up. They also put a firmware read in the same cycle as a host write, which reveals the wrong priority. Output loads are tried with both settings of the aux select and with data-port reads under both settings of `hw_clear_en`. These cases separate hardware clearing from firmware clearing, and a load colliding with a clearing read shows which side wins. A long seeded random run mixes all strobes, including off-map addresses and simultaneous host reads and writes. A bench model predicts each register from the requirements, which exposes any missed or extra state change.

// File: rtl/kbc_pkg.sv
// Shared constants for the keyboard controller host interface.
// Assumes a byte-wide status register with fixed flag positions.
package kbc_pkg;
    localparam int KBC_DW  = 8;
    localparam int STS_OBF = 0;
    localparam int STS_IBF = 1;
    localparam int STS_CD  = 3;
    // Bits the firmware may drive directly in the status byte.
    localparam logic [KBC_DW-1:0] CTL_MASK = 8'hF4;
    localparam logic [KBC_DW-1:0] IDLE_READ = 8'hFF;
endpackage

// File: rtl/kbc_port_decode.sv
// Address decoder for the two host ports.
// Turns the host strobes into per-port write and read events.
// Assumes DATA_PORT and CMD_PORT differ. Strobes are one cycle wide.
module kbc_port_decode #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0060,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 16'h0064
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic              addr_is_data,
    output logic              addr_is_cmd,
    output logic              data_wr,
    output logic              cmd_wr,
    output logic              data_rd
);
    // Compare the address against both ports and qualify the strobes.
    always_comb begin
        addr_is_data = (host_addr == DATA_PORT);
        addr_is_cmd  = (host_addr == CMD_PORT);
        data_wr      = host_wr && addr_is_data;
        cmd_wr       = host_wr && addr_is_cmd;
        data_rd      = host_rd && addr_is_data;
    end
endmodule

// File: rtl/kbc_input_side.sv
// Input byte, command flag and input-full flag.
// The host fills the byte. The firmware drains it with a read strobe.
// Assumes data_wr and cmd_wr are never high together.
module kbc_input_side #(
    parameter int DW = kbc_pkg::KBC_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic          cmd_wr,
    input  logic [DW-1:0] wdata,
    input  logic          ec_rd,
    output logic [DW-1:0] in_data,
    output logic          cd_flag,
    output logic          ibf
);
    logic [DW-1:0] in_q;
    logic          cd_q;
    logic          ibf_q;
    logic          any_wr;

    assign any_wr = data_wr || cmd_wr;

    // Capture host writes; a host write beats a same-cycle firmware drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q  <= '0;
            cd_q  <= 1'b0;
            ibf_q <= 1'b0;
        end else if (any_wr) begin
            in_q  <= wdata;
            cd_q  <= cmd_wr;
            ibf_q <= 1'b1;
        end else if (ec_rd) begin
            ibf_q <= 1'b0;
        end
    end

    assign in_data = in_q;
    assign cd_flag = cd_q;
    assign ibf     = ibf_q;

    // R1: data-port write lands with command flag low
    a_r1_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && data_wr) |=> (ibf_q && !cd_q && in_q == $past(wdata)));

    // R2: command-port write lands with command flag high
    a_r2_cmd_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cmd_wr) |=> (ibf_q && cd_q && in_q == $past(wdata)));

    // R4: firmware read drains input-full when no host write collides
    a_r4_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ec_rd && !any_wr) |=> !ibf_q);

    // R8: without strobes the input side holds still
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !any_wr && !ec_rd) |=> $stable({in_q, cd_q, ibf_q}));
endmodule

// File: rtl/kbc_output_side.sv
// Output byte, output-full flag and the two host interrupt lines.
// The firmware loads the byte. A host data read clears the flag and
// interrupts only when hw_clear_en is set; otherwise the firmware clears them.
// Assumes single-cycle strobes.
module kbc_output_side #(
    parameter int DW = kbc_pkg::KBC_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ec_load,
    input  logic [DW-1:0] ec_data,
    input  logic          ec_aux,
    input  logic          ec_clr,
    input  logic          host_data_rd,
    input  logic          hw_clear_en,
    output logic [DW-1:0] out_data,
    output logic          obf,
    output logic          kirq,
    output logic          mirq
);
    logic [DW-1:0] out_q;
    logic          obf_q;
    logic          kirq_q;
    logic          mirq_q;
    logic          clear_now;

    assign clear_now = ec_clr || (host_data_rd && hw_clear_en);

    // Load has priority over either clearing path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            obf_q  <= 1'b0;
            kirq_q <= 1'b0;
            mirq_q <= 1'b0;
        end else if (ec_load) begin
            out_q  <= ec_data;
            obf_q  <= 1'b1;
            kirq_q <= !ec_aux;
            mirq_q <= ec_aux;
        end else if (clear_now) begin
            obf_q  <= 1'b0;
            kirq_q <= 1'b0;
            mirq_q <= 1'b0;
        end
    end

    assign out_data = out_q;
    assign obf      = obf_q;
    assign kirq     = kirq_q;
    assign mirq     = mirq_q;

    // R5: load sets output-full and the selected interrupt only
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ec_load) |=> (obf_q && out_q == $past(ec_data)
                                && kirq_q == !$past(ec_aux) && mirq_q == $past(ec_aux)));

    // R5: an interrupt line is only high while output-full is set
    a_r5_irq_needs_obf: assert property (@(posedge clk) disable iff (!rst_n)
        (kirq_q || mirq_q) |-> obf_q);

    // R6: hardware clearing on host data read when enabled
    a_r6_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && host_data_rd && hw_clear_en && !ec_load)
        |=> (!obf_q && !kirq_q && !mirq_q));

    // R7: host data read without the enable leaves the flags alone
    a_r7_no_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && host_data_rd && !hw_clear_en && !ec_load && !ec_clr)
        |=> $stable({obf_q, kirq_q, mirq_q}));

    // R7: firmware clear drops flag and interrupts
    a_r7_fw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ec_clr && !ec_load) |=> (!obf_q && !kirq_q && !mirq_q));
endmodule

// File: rtl/kbc_host_if.sv
// Host register interface of an 8042-style keyboard controller.
// Decodes a data port and a command/status port, holds the input and
// output bytes and the status byte, and drives keyboard and mouse interrupts.
// Assumes one clock, synchronous active-low reset and one-cycle strobes.
module kbc_host_if #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0060,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 16'h0064
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              hw_clear_en,
    input  logic              ec_in_rd,
    output logic [7:0]        ec_in_data,
    output logic              ec_in_cmd,
    input  logic              ec_out_wr,
    input  logic [7:0]        ec_out_data,
    input  logic              ec_out_aux,
    input  logic              ec_obf_clr,
    input  logic              ec_ctl_wr,
    input  logic [7:0]        ec_ctl_data,
    output logic [7:0]        ec_status,
    output logic              kirq,
    output logic              mirq
);
    import kbc_pkg::*;

    logic              addr_is_data;
    logic              addr_is_cmd;
    logic              data_wr;
    logic              cmd_wr;
    logic              data_rd;
    logic [KBC_DW-1:0] in_byte;
    logic [KBC_DW-1:0] out_byte;
    logic              cd_flag;
    logic              ibf;
    logic              obf;
    logic [KBC_DW-1:0] ctl_q;
    logic [KBC_DW-1:0] status;

    kbc_port_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_PORT(DATA_PORT),
        .CMD_PORT (CMD_PORT)
    ) i_decode (
        .host_addr   (host_addr),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .addr_is_data(addr_is_data),
        .addr_is_cmd (addr_is_cmd),
        .data_wr     (data_wr),
        .cmd_wr      (cmd_wr),
        .data_rd     (data_rd)
    );

    kbc_input_side #(.DW(KBC_DW)) i_input (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_wr(data_wr),
        .cmd_wr (cmd_wr),
        .wdata  (host_wdata),
        .ec_rd  (ec_in_rd),
        .in_data(in_byte),
        .cd_flag(cd_flag),
        .ibf    (ibf)
    );

    kbc_output_side #(.DW(KBC_DW)) i_output (
        .clk         (clk),
        .rst_n       (rst_n),
        .ec_load     (ec_out_wr),
        .ec_data     (ec_out_data),
        .ec_aux      (ec_out_aux),
        .ec_clr      (ec_obf_clr),
        .host_data_rd(data_rd),
        .hw_clear_en (hw_clear_en),
        .out_data    (out_byte),
        .obf         (obf),
        .kirq        (kirq),
        .mirq        (mirq)
    );

    // Firmware-owned status bits; the flag positions are kept at zero here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ec_ctl_wr) begin
            ctl_q <= ec_ctl_data & CTL_MASK;
        end
    end

    // Merge the hardware flags into the firmware bits.
    always_comb begin
        status          = ctl_q;
        status[STS_OBF] = obf;
        status[STS_IBF] = ibf;
        status[STS_CD]  = cd_flag;
    end

    // Select the byte the host sees from the current address.
    always_comb begin
        if (addr_is_cmd) begin
            host_rdata = status;
        end else if (addr_is_data) begin
            host_rdata = out_byte;
        end else begin
            host_rdata = IDLE_READ;
        end
    end

    assign ec_in_data = in_byte;
    assign ec_in_cmd  = cd_flag;
    assign ec_status  = status;

    // R9: firmware bits only move on a firmware status write
    a_r9_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !ec_ctl_wr) |=> ((ec_status & CTL_MASK) == $past(ec_status & CTL_MASK)));

    // R9: a firmware status write leaves the hardware flags to their own logic
    a_r9_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ec_ctl_wr) |=> ((ec_status & CTL_MASK) == ($past(ec_ctl_data) & CTL_MASK)));

    // R10: reset empties every register and drops both interrupts
    a_r10_reset: assert property (@(posedge clk)
        !rst_n |=> (ec_status == 8'h00 && ec_in_data == 8'h00 && !kirq && !mirq));
endmodule

// File: tb/test_kbc_host_if.sv
module test_kbc_host_if;
    localparam logic [15:0] DP = 16'h0060;
    localparam logic [15:0] CP = 16'h0064;
    localparam logic [15:0] XP = 16'h0061;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] host_addr;
    logic        host_wr, host_rd;
    logic [7:0]  host_wdata;
    logic [7:0]  host_rdata;
    logic        hw_clear_en;
    logic        ec_in_rd;
    logic [7:0]  ec_in_data;
    logic        ec_in_cmd;
    logic        ec_out_wr;
    logic [7:0]  ec_out_data;
    logic        ec_out_aux;
    logic        ec_obf_clr;
    logic        ec_ctl_wr;
    logic [7:0]  ec_ctl_data;
    logic [7:0]  ec_status;
    logic        kirq, mirq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model of the registers
    logic [7:0] m_in, m_out, m_ctl;
    logic       m_cd, m_ibf, m_obf, m_kirq, m_mirq;

    always #4 clk = ~clk;

    kbc_host_if i_kbc_host_if (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .hw_clear_en(hw_clear_en), .ec_in_rd(ec_in_rd), .ec_in_data(ec_in_data),
        .ec_in_cmd(ec_in_cmd), .ec_out_wr(ec_out_wr), .ec_out_data(ec_out_data),
        .ec_out_aux(ec_out_aux), .ec_obf_clr(ec_obf_clr), .ec_ctl_wr(ec_ctl_wr),
        .ec_ctl_data(ec_ctl_data), .ec_status(ec_status), .kirq(kirq), .mirq(mirq)
    );

    function automatic logic [7:0] exp_status();
        return (m_ctl & 8'hF4) | {4'b0, m_cd, 1'b0, m_ibf, m_obf};
    endfunction

    function automatic logic [7:0] exp_rdata();
        if (host_addr == CP) return exp_status();
        if (host_addr == DP) return m_out;
        return 8'hFF;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        m_in = 0; m_out = 0; m_ctl = 0;
        m_cd = 0; m_ibf = 0; m_obf = 0; m_kirq = 0; m_mirq = 0;
    endtask

    // next-state rules taken from the requirements
    task automatic model_step();
        bit vwr;
        vwr = host_wr && (host_addr == DP || host_addr == CP);
        if (vwr) begin
            m_in = host_wdata; m_cd = (host_addr == CP); m_ibf = 1;
        end else if (ec_in_rd) m_ibf = 0;
        if (ec_ctl_wr) m_ctl = ec_ctl_data & 8'hF4;
        if (ec_out_wr) begin
            m_out = ec_out_data; m_obf = 1; m_kirq = !ec_out_aux; m_mirq = ec_out_aux;
        end else if (ec_obf_clr || (host_rd && host_addr == DP && hw_clear_en)) begin
            m_obf = 0; m_kirq = 0; m_mirq = 0;
        end
    endtask

    task automatic idle_inputs();
        host_wr = 0; host_rd = 0; ec_in_rd = 0; ec_out_wr = 0;
        ec_obf_clr = 0; ec_ctl_wr = 0;
    endtask

    task automatic check_state(input string tag);
        chk({tag, " ec_in_data"}, ec_in_data, m_in);
        chk({tag, " ec_in_cmd"}, {7'b0, ec_in_cmd}, {7'b0, m_cd});
        chk({tag, " ec_status"}, ec_status, exp_status());
        chk({tag, " kirq"}, {7'b0, kirq}, {7'b0, m_kirq});
        chk({tag, " mirq"}, {7'b0, mirq}, {7'b0, m_mirq});
    endtask

    // Inputs already set after a falling edge: check read mux, clock, check state.
    task automatic tick(input string tag);
        #1;
        chk("R3 host_rdata", host_rdata, exp_rdata());
        model_step();
        @(negedge clk);
        idle_inputs();
        check_state(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; host_addr = DP; host_wdata = 0; hw_clear_en = 0;
        ec_out_data = 0; ec_out_aux = 0; ec_ctl_data = 0;
        idle_inputs();
        model_reset();
        repeat (3) @(negedge clk);
        // R10: reset state
        check_state("R10");
        chk("R10 rdata data port", host_rdata, 8'h00);
        rst_n = 1;

        // R1: data port write
        host_addr = DP; host_wr = 1; host_wdata = 8'hA5; tick("R1");
        chk("R1 ibf bit", {7'b0, ec_status[1]}, 8'h01);
        chk("R1 cd bit", {7'b0, ec_status[3]}, 8'h00);
        // R4: firmware drain
        ec_in_rd = 1; tick("R4");
        chk("R4 ibf cleared", {7'b0, ec_status[1]}, 8'h00);
        // R2: command port write
        host_addr = CP; host_wr = 1; host_wdata = 8'hD4; tick("R2");
        chk("R2 cd bit", {7'b0, ec_status[3]}, 8'h01);
        // R8: overwrite while full
        host_addr = DP; host_wr = 1; host_wdata = 8'h11; tick("R8");
        chk("R8 overwrite byte", ec_in_data, 8'h11);
        chk("R8 cd updated", {7'b0, ec_in_cmd}, 8'h00);
        // R4: collision, host write wins
        host_addr = CP; host_wr = 1; host_wdata = 8'h22; ec_in_rd = 1; tick("R4");
        chk("R4 write beats drain", {7'b0, ec_status[1]}, 8'h01);
        // R5: keyboard load
        ec_out_wr = 1; ec_out_data = 8'h5A; ec_out_aux = 0; tick("R5");
        chk("R5 kirq", {7'b0, kirq}, 8'h01);
        // R7: read without enable keeps flags
        hw_clear_en = 0; host_addr = DP; host_rd = 1; tick("R7");
        chk("R7 obf kept", {7'b0, ec_status[0]}, 8'h01);
        chk("R7 kirq kept", {7'b0, kirq}, 8'h01);
        ec_obf_clr = 1; tick("R7");
        chk("R7 fw clear", {6'b0, kirq, mirq}, 8'h00);
        // R5: mouse load
        ec_out_wr = 1; ec_out_data = 8'h3C; ec_out_aux = 1; tick("R5");
        chk("R5 mirq only", {6'b0, kirq, mirq}, 8'h01);
        // R6: hardware clear
        hw_clear_en = 1; host_addr = DP; host_rd = 1; tick("R6");
        chk("R6 cleared", {5'b0, ec_status[0], kirq, mirq}, 8'h00);
        // R6: load beats clearing read
        host_rd = 1; ec_out_wr = 1; ec_out_data = 8'h77; ec_out_aux = 0; tick("R6");
        chk("R6 load wins", {6'b0, ec_status[0], kirq}, 8'h03);
        // R9: firmware status write
        ec_ctl_wr = 1; ec_ctl_data = 8'hFF; tick("R9");
        chk("R9 masked bits", ec_status & 8'hF4, 8'hF4);
        chk("R9 flags kept", ec_status & 8'h0B, 8'h0B);
        // R3: off-map address ignored
        host_addr = XP; host_wr = 1; host_wdata = 8'hEE; host_rd = 1; tick("R3");
        chk("R3 off-map rdata", host_rdata, 8'hFF);
        chk("R3 off-map no write", ec_in_data, 8'h22);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int a;
            a = $urandom_range(0, 3);
            host_addr   = (a == 0) ? XP : ((a == 1) ? CP : DP);
            host_wr     = ($urandom_range(0, 3) == 0);
            host_rd     = ($urandom_range(0, 2) == 0);
            host_wdata  = 8'($urandom);
            hw_clear_en = $urandom_range(0, 1) == 1;
            ec_in_rd    = ($urandom_range(0, 3) == 0);
            ec_out_wr   = ($urandom_range(0, 4) == 0);
            ec_out_data = 8'($urandom);
            ec_out_aux  = $urandom_range(0, 1) == 1;
            ec_obf_clr  = ($urandom_range(0, 7) == 0);
            ec_ctl_wr   = ($urandom_range(0, 9) == 0);
            ec_ctl_data = 8'($urandom);
            if ($urandom_range(0, 199) == 0) begin
                rst_n = 0;
                #1;
                model_reset();
                @(negedge clk);
                idle_inputs();
                rst_n = 1;
                check_state("R10");
            end else begin
                tick("R8");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule